// File: doc/BRIEF.md
# Vector Store Decode and Address Unit

This unit takes one 32-bit instruction word at a time on a valid/ready port. It checks the word against two encodings of the same 128-bit vector store. The narrow form names one of 32 vector registers. The wide form names one of 128, and its register index is split across two non-adjacent bit fields. The decode drives the read indices of the vector register file and of two 64-bit general registers, and the register files answer combinationally.

When the word matches, the unit forms an effective address. It adds the base and the index, with a zero base field meaning a literal zero. It then clears the low four bits and keeps the low 32 bits, and no alignment fault is ever raised. The unit holds a single 16-byte write request, with all byte enables set, until the memory port takes it. The vector is laid out so that its most significant byte goes to the lowest address.

On the cycle the write is taken, the unit also raises a reservation-invalidate for the same aligned address, but only if the reservation facility was enabled and held a reservation when the instruction was accepted. A word that matches neither form is still consumed. It produces a one-cycle "not a vector store" pulse and no write.

Top module: `vst_unit`

## Requirements
- R1: Bit 0 is the most significant bit of the word. The narrow form matches when bits 0-5 equal 31 and bits 21-30 equal 231, and bit 31 is ignored. Its vector index is bits 6-10, its base field is bits 11-15 and its index field is bits 16-20.
- R2: The wide form matches when bits 0-5 equal 4 and bits 21-27 equal 28. Its 7-bit vector index is bits 28-29 (high) joined to bits 6-10 (low). Base and index fields sit where they do in the narrow form, and bits 30-31 are ignored.
- R3: A word matching neither form is accepted. `not_vstore` is high for exactly the cycle after acceptance, and no write is issued.
- R4: A base field of 0 selects a 64-bit zero base, whatever general register 0 holds. The index register is always used.
- R5: `mem_addr` is the low 32 bits of the 64-bit wrapping sum of base and index, with bits 3:0 forced to 0.
- R6: The byte for address `mem_addr+k` (k = 0..15) is carried on `mem_data[8k+7:8k]` and equals bits [127-8k : 120-8k] of the vector register.
- R7: Every matching instruction gives exactly one write request, and that request has `mem_be` equal to 16'hFFFF.
- R8: `inv_valid` is high only in the cycle the write is taken (`mem_valid && mem_ready`), and only if `resv_enable` and `resv_active` were both high at acceptance. `inv_addr` then equals `mem_addr`.
- R9: While `mem_valid` is high and `mem_ready` is low, the request holds with stable address and data, and `in_ready` is low.
- R10: `mem_valid` rises in the cycle after a matching word is accepted.
- R11: After reset, `mem_valid`, `inv_valid` and `not_vstore` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can take a word |
| in_word | input | 32 | Instruction word |
| not_vstore | output | 1 | Pulse: the accepted word was not a vector store |
| vr_idx | output | 7 | Vector register read index |
| vr_data | input | 128 | Vector register read data |
| ra_idx | output | 5 | Base general register index |
| ra_data | input | 64 | Base general register data |
| rb_idx | output | 5 | Index general register index |
| rb_data | input | 64 | Index general register data |
| resv_enable | input | 1 | Reservation facility enabled |
| resv_active | input | 1 | At least one reservation is held |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | 32 | Aligned write address |
| mem_data | output | 128 | Write data, byte k at address+k |
| mem_be | output | 16 | Byte enables |
| inv_valid | output | 1 | Reservation invalidate strobe |
| inv_addr | output | 32 | Address to invalidate |

## Verification
The assertions assume that the register files answer in the same cycle as the index, and that reset is held low across at least one clock edge before any traffic. The memory side is free to hold `mem_ready` low for any number of cycles, and the hold-stable checks exist for exactly that case. The stimulus drives every input at the falling edge, keeps the register arrays constant while a request is in flight, and gives the reservation inputs a defined value whenever `in_valid` is high.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic [1:0] {
    FORM_NONE   = 2'd0,
    FORM_NARROW = 2'd1,
    FORM_WIDE   = 2'd2
  } vst_form_e;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NARROW_OPC  = 31;
  localparam int unsigned NARROW_XO   = 231;
  localparam int unsigned WIDE_OPC    = 4;
  localparam int unsigned WIDE_XO     = 28;

  // Field picker using MSB-zero numbering: first..last inclusive, right aligned.
  function automatic logic [WORD_W-1:0] msb0_field(input logic [WORD_W-1:0] w,
                                                   input int unsigned first,
                                                   input int unsigned last);
    logic [WORD_W-1:0] mask;
    mask = (WORD_W'(1) << (last - first + 1)) - WORD_W'(1);
    return (w >> (WORD_W - 1 - last)) & mask;
  endfunction

endpackage

// File: rtl/vst_decode.sv
module vst_decode
  import vst_pkg::*;
#(
  parameter int unsigned VR_IDX_W = 7,
  parameter int unsigned GR_IDX_W = 5
) (
  input  logic [WORD_W-1:0]   word,
  output vst_form_e           form,
  output logic                hit,
  output logic [VR_IDX_W-1:0] vr_idx,
  output logic [GR_IDX_W-1:0] ra_idx,
  output logic [GR_IDX_W-1:0] rb_idx,
  output logic                base_zero
);
  logic [5:0]  opc;
  logic [9:0]  xo_long;
  logic [6:0]  xo_short;
  logic [4:0]  vlow;
  logic [1:0]  vhigh;
  logic        is_narrow;
  logic        is_wide;

  always_comb begin
    opc      = 6'(msb0_field(word, 0, 5));
    xo_long  = 10'(msb0_field(word, 21, 30));
    xo_short = 7'(msb0_field(word, 21, 27));
    vlow     = 5'(msb0_field(word, 6, 10));
    vhigh    = 2'(msb0_field(word, 28, 29));
    ra_idx   = GR_IDX_W'(msb0_field(word, 11, 15));
    rb_idx   = GR_IDX_W'(msb0_field(word, 16, 20));
  end

  assign is_narrow = (opc == 6'(NARROW_OPC)) && (xo_long  == 10'(NARROW_XO));
  assign is_wide   = (opc == 6'(WIDE_OPC))   && (xo_short == 7'(WIDE_XO));

  always_comb begin
    if (is_narrow) begin
      form   = FORM_NARROW;
      vr_idx = VR_IDX_W'(vlow);
    end else if (is_wide) begin
      form   = FORM_WIDE;
      vr_idx = VR_IDX_W'({vhigh, vlow});
    end else begin
      form   = FORM_NONE;
      vr_idx = VR_IDX_W'(vlow);
    end
  end

  assign hit       = (form != FORM_NONE);
  assign base_zero = (ra_idx == '0);

  // R1/R2: a narrow-form decode never names a register above 31
  always_comb begin
    if (form == FORM_NARROW) begin
      a_narrow_range_r1: assert (vr_idx < VR_IDX_W'(32));
    end
  end
endmodule

// File: rtl/vst_agen.sv
module vst_agen #(
  parameter int unsigned GPR_W      = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic              base_zero,
  input  logic [GPR_W-1:0]  base_val,
  input  logic [GPR_W-1:0]  index_val,
  output logic [ADDR_W-1:0] ea
);
  function automatic logic [ADDR_W-1:0] aligned_ea(input logic [GPR_W-1:0] b,
                                                   input logic [GPR_W-1:0] x);
    logic [GPR_W-1:0] sum;
    sum = b + x;
    sum[ALIGN_BITS-1:0] = '0;
    return sum[ADDR_W-1:0];
  endfunction

  logic [GPR_W-1:0] base_eff;

  assign base_eff = base_zero ? '0 : base_val;
  assign ea       = aligned_ea(base_eff, index_val);

  // R5: the address never carries low bits
  always_comb begin
    a_ea_aligned_r5: assert (ea[ALIGN_BITS-1:0] == '0);
  end
endmodule

// File: rtl/vst_lane_swap.sv
module vst_lane_swap #(
  parameter int unsigned NBYTES = 16
) (
  input  logic [8*NBYTES-1:0] vec_in,
  output logic [8*NBYTES-1:0] bus_out
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign bus_out[8*k +: 8] = vec_in[8*(NBYTES-1-k) +: 8];
  end
endmodule

// File: rtl/vst_issue.sv
module vst_issue #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NBYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                hit,
  input  logic                inv_req,
  input  logic [ADDR_W-1:0]   ea,
  input  logic [8*NBYTES-1:0] bus_data,
  output logic                not_vstore,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [8*NBYTES-1:0] mem_data,
  output logic [NBYTES-1:0]   mem_be,
  output logic                inv_valid,
  output logic [ADDR_W-1:0]   inv_addr
);
  logic                accept;
  logic                load_store;
  logic                reject;
  logic                fire;
  logic                stage_v;
  logic                stage_inv;
  logic                rej_q;
  logic [ADDR_W-1:0]   stage_addr;
  logic [8*NBYTES-1:0] stage_data;

  assign in_ready   = !stage_v || mem_ready;
  assign accept     = in_valid && in_ready;
  assign load_store = accept && hit;
  assign reject     = accept && !hit;
  assign fire       = stage_v && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_v    <= 1'b0;
      stage_inv  <= 1'b0;
      rej_q      <= 1'b0;
      stage_addr <= '0;
      stage_data <= '0;
    end else begin
      rej_q <= reject;
      if (load_store) begin
        stage_v    <= 1'b1;
        stage_inv  <= inv_req;
        stage_addr <= ea;
        stage_data <= bus_data;
      end else if (fire) begin
        stage_v   <= 1'b0;
        stage_inv <= 1'b0;
      end
    end
  end

  assign not_vstore = rej_q;
  assign mem_valid  = stage_v;
  assign mem_addr   = stage_addr;
  assign mem_data   = stage_data;
  assign mem_be     = stage_v ? '1 : '0;
  assign inv_valid  = fire && stage_inv;
  assign inv_addr   = stage_addr;

  // R9: a stalled request holds steady
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R9: no new word is taken during a stall
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !in_ready);

  // R8: invalidate only with a taken write, same address
  p_inv_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (mem_valid && mem_ready && inv_addr == mem_addr));

  // R7: full byte mask on every request
  p_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == '1));

  // R3: a reject pulse lasts one cycle for a single accepted word
  p_reject_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit) |=> (not_vstore && !$rose(mem_valid)));

  // R10: a matching accept raises the request on the next cycle
  p_issue_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit) |=> mem_valid);
endmodule

// File: rtl/vst_unit.sv
module vst_unit
  import vst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GPR_W    = 64,
  parameter int unsigned VR_IDX_W = 7,
  parameter int unsigned GR_IDX_W = 5,
  parameter int unsigned NBYTES   = 16,
  localparam int unsigned VEC_W      = 8 * NBYTES,
  localparam int unsigned ALIGN_BITS = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                not_vstore,
  output logic [VR_IDX_W-1:0] vr_idx,
  input  logic [VEC_W-1:0]    vr_data,
  output logic [GR_IDX_W-1:0] ra_idx,
  input  logic [GPR_W-1:0]    ra_data,
  output logic [GR_IDX_W-1:0] rb_idx,
  input  logic [GPR_W-1:0]    rb_data,
  input  logic                resv_enable,
  input  logic                resv_active,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [VEC_W-1:0]    mem_data,
  output logic [NBYTES-1:0]   mem_be,
  output logic                inv_valid,
  output logic [ADDR_W-1:0]   inv_addr
);
  vst_form_e         dec_form;
  logic              dec_hit;
  logic              dec_base_zero;
  logic [ADDR_W-1:0] ea;
  logic [VEC_W-1:0]  bus_data;
  logic              inv_req;

  vst_decode #(.VR_IDX_W(VR_IDX_W), .GR_IDX_W(GR_IDX_W)) u_decode (
    .word      (in_word),
    .form      (dec_form),
    .hit       (dec_hit),
    .vr_idx    (vr_idx),
    .ra_idx    (ra_idx),
    .rb_idx    (rb_idx),
    .base_zero (dec_base_zero)
  );

  vst_agen #(.GPR_W(GPR_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
    .base_zero (dec_base_zero),
    .base_val  (ra_data),
    .index_val (rb_data),
    .ea        (ea)
  );

  vst_lane_swap #(.NBYTES(NBYTES)) u_swap (
    .vec_in  (vr_data),
    .bus_out (bus_data)
  );

  assign inv_req = resv_enable && resv_active;

  vst_issue #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .hit        (dec_hit),
    .inv_req    (inv_req),
    .ea         (ea),
    .bus_data   (bus_data),
    .not_vstore (not_vstore),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_be     (mem_be),
    .inv_valid  (inv_valid),
    .inv_addr   (inv_addr)
  );

  // R1/R2: the form and the hit flag agree
  always_comb begin
    a_form_hit_r2: assert (dec_hit == (dec_form != FORM_NONE));
  end

  // R11: idle outputs in the first cycle out of reset
  p_reset_idle_r11: assert property (@(posedge clk)
    !rst_n |=> (!mem_valid && !not_vstore && !inv_valid && in_ready));
endmodule

// File: tb/vst_unit_test.sv
`timescale 1ns/1ps
module vst_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic         not_vstore;
  logic [6:0]   vr_idx;
  logic [127:0] vr_data;
  logic [4:0]   ra_idx, rb_idx;
  logic [63:0]  ra_data, rb_data;
  logic         resv_enable = 1'b0, resv_active = 1'b0;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [31:0]  mem_addr, inv_addr;
  logic [127:0] mem_data;
  logic [15:0]  mem_be;
  logic         inv_valid;

  logic [63:0]  gprs [32];
  logic [127:0] vrs  [128];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign vr_data = vrs[vr_idx];
  assign ra_data = gprs[ra_idx];
  assign rb_data = gprs[rb_idx];

  vst_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .not_vstore(not_vstore), .vr_idx(vr_idx), .vr_data(vr_data),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .resv_enable(resv_enable), .resv_active(resv_active), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  function automatic logic [31:0] enc_n(input int vs, input int ra, input int rb);
    return {6'd31, 5'(vs), 5'(ra), 5'(rb), 10'd231, 1'b0};
  endfunction
  function automatic logic [31:0] enc_w(input int v, input int ra, input int rb, input int rsv);
    logic [6:0] v7;
    v7 = 7'(v);
    return {6'd4, v7[4:0], 5'(ra), 5'(rb), 7'd28, v7[6:5], 2'(rsv)};
  endfunction

  localparam int NV = 8;
  localparam logic [31:0] TBL_W [NV] = '{
    enc_n(5, 3, 4),
    enc_n(31, 0, 7),
    enc_w(127, 5, 6, 3),
    enc_w(64, 0, 2, 0),
    enc_n(9, 0, 0) | 32'h1,
    enc_n(1, 1, 1) ^ 32'h2,
    enc_w(3, 1, 1, 0) ^ 32'h10,
    32'h0
  };
  localparam logic [1:0] TBL_R [NV] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11};

  // Independent model, MSB-zero numbering
  function automatic int bits(input logic [31:0] w, input int first, input int last);
    return int'((w >> (31 - last)) & ((32'd1 << (last - first + 1)) - 1));
  endfunction
  function automatic int kind(input logic [31:0] w);
    if (bits(w, 0, 5) == 31 && bits(w, 21, 30) == 231) return 1;
    if (bits(w, 0, 5) == 4 && bits(w, 21, 27) == 28) return 2;
    return 0;
  endfunction
  function automatic int vidx(input logic [31:0] w);
    if (kind(w) == 2) return bits(w, 28, 29) * 32 + bits(w, 6, 10);
    return bits(w, 6, 10);
  endfunction
  function automatic logic [31:0] exp_addr(input logic [31:0] w);
    logic [63:0] b, s;
    b = (bits(w, 11, 15) == 0) ? 64'd0 : gprs[bits(w, 11, 15)];
    s = b + gprs[bits(w, 16, 20)];
    return {s[31:4], 4'h0};
  endfunction
  function automatic logic [127:0] exp_bus(input logic [127:0] v);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = v[127 - 8*k -: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [31:0] w, input logic [1:0] rv);
    int kd;
    kd = kind(w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; resv_enable = rv[1]; resv_active = rv[0];
    #1;
    if (kd == 1) chk(vr_idx == 7'(vidx(w)), "R1 narrow index", 128'(vr_idx), 128'(vidx(w)));
    if (kd == 2) chk(vr_idx == 7'(vidx(w)), "R2 wide index", 128'(vr_idx), 128'(vidx(w)));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (kd == 0) begin
      chk(not_vstore == 1'b1, "R3 reject pulse", 128'(not_vstore), 128'd1);
      chk(mem_valid == 1'b0, "R3 no write", 128'(mem_valid), 128'd0);
    end else begin
      chk(mem_valid == 1'b1, "R10 write next cycle", 128'(mem_valid), 128'd1);
      chk(not_vstore == 1'b0, "R3 no reject on match", 128'(not_vstore), 128'd0);
      chk(mem_addr == exp_addr(w), "R4 R5 address", 128'(mem_addr), 128'(exp_addr(w)));
      chk(mem_data == exp_bus(vrs[vidx(w)]), "R6 byte lanes", mem_data, exp_bus(vrs[vidx(w)]));
      chk(mem_be == 16'hFFFF, "R7 byte enables", 128'(mem_be), 128'hFFFF);
      chk(inv_valid == (rv == 2'b11), "R8 invalidate", 128'(inv_valid), 128'(rv == 2'b11));
      if (rv == 2'b11) chk(inv_addr == exp_addr(w), "R8 invalidate address", 128'(inv_addr), 128'(exp_addr(w)));
    end
    @(posedge clk);
    @(negedge clk);
    chk(mem_valid == 1'b0 && not_vstore == 1'b0, "R7 single request", 128'({mem_valid, not_vstore}), 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held_a;
    logic [127:0] held_d;
    for (int i = 0; i < 32; i++) gprs[i] = 64'h0000_0001_0000_0013 * 64'(i);
    for (int i = 0; i < 128; i++)
      for (int k = 0; k < 16; k++) vrs[i][127 - 8*k -: 8] = 8'(i * 7 + k * 13 + 1);
    gprs[0] = 64'hDEAD_0000_0000_0400;
    gprs[2] = 64'hABCD_1234_5678_9ABF;
    gprs[3] = 64'h0000_0000_0000_1000;
    gprs[4] = 64'h0000_0000_0000_0237;
    gprs[5] = 64'hFFFF_FFFF_FFFF_FFFF;
    gprs[6] = 64'h0000_0000_0000_0025;
    gprs[7] = 64'h0000_0012_3456_789F;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_valid == 0 && inv_valid == 0 && not_vstore == 0 && in_ready == 1,
        "R11 reset state", 128'({mem_valid, inv_valid, not_vstore, in_ready}), 128'b0001);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) run_word(TBL_W[n], TBL_R[n]);

    // R5: 64-bit wrap then alignment (FFFF..FF + 0x25 -> 0x20)
    chk(exp_addr(enc_w(0, 5, 6, 0)) == 32'h20, "R5 wrap model", 128'(exp_addr(enc_w(0, 5, 6, 0))), 128'h20);

    // R9: stall with memory not ready
    mem_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_word = enc_n(12, 3, 4); resv_enable = 1'b1; resv_active = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    held_a = mem_addr; held_d = mem_data;
    chk(mem_valid && !in_ready, "R9 stall blocks input", 128'({mem_valid, in_ready}), 128'b10);
    chk(inv_valid == 1'b0, "R8 no invalidate while stalled", 128'(inv_valid), 128'd0);
    repeat (3) begin
      @(negedge clk);
      chk(mem_valid && mem_addr == held_a && mem_data == held_d, "R9 request held",
          128'(mem_addr), 128'(held_a));
    end
    chk(held_a == 32'h1230, "R5 stalled address", 128'(held_a), 128'h1230);
    mem_ready = 1'b1;
    #1;
    chk(inv_valid == 1'b1 && inv_addr == 32'h1230, "R8 invalidate on release", 128'(inv_addr), 128'h1230);
    chk(in_ready == 1'b1, "R9 ready on release", 128'(in_ready), 128'd1);
    @(posedge clk);
    @(negedge clk);
    chk(mem_valid == 1'b0, "R7 one write after stall", 128'(mem_valid), 128'd0);

    // R11: reset in the middle of a stalled request
    mem_ready = 1'b0;
    in_valid = 1'b1; in_word = enc_n(2, 2, 2);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(mem_valid == 0 && in_ready == 1, "R11 reset clears request", 128'({mem_valid, in_ready}), 128'b01);
    rst_n = 1'b1; mem_ready = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule